// File: doc/BRIEF.md
# Write-Only Serial Display Byte Receiver

This block receives bytes for a display controller from a host over a synchronous serial link. The link has five wires: a serial clock, a data line, a data/command select line, an active-low select and an active-high select. The host shifts eight bits in on rising serial-clock edges, most significant bit first. On the eighth rising edge, the data/command line routes the finished byte either to display memory or to the command register. The link is write-only and the block drives nothing back to the host.

All five serial wires are resynchronized into the system clock domain, and the serial clock is edge-detected there. The block presents each finished byte on a registered output as a strobe that lasts one system cycle. With the strobe come the eight-bit value and a flag that says where the byte belongs. The byte and flag then stay unchanged until the next byte arrives. Dropping either select clears the bit count, so a partial byte is discarded. When a byte completes, the count wraps to zero, so the host can stream bytes back to back without toggling the selects.

Top module: `serial_display_rx`

## Requirements
- R1: While reset is held and right after it, `wr_valid`, `wr_data` and `wr_is_data` are all 0.
- R2: Data bits are captured on rising serial-clock edges, first bit into `wr_data[7]`, eighth bit into `wr_data[0]`.
- R3: `wr_is_data` equals the level of `ser_dc` at the eighth rising edge, 1 meaning display memory and 0 meaning command register. Its level at the first seven edges has no effect.
- R4: Each completed byte raises `wr_valid` for exactly one system clock cycle.
- R5: `wr_data` and `wr_is_data` change only together with a `wr_valid` pulse and hold their value in between.
- R6: Serial clock edges count only while `sel_lo_n` is 0 and `sel_hi` is 1. Edges at any other time produce no byte and do not advance the bit count.
- R7: Leaving the selected state clears the bit count, so the next selected edge is taken as the first bit of a new byte.
- R8: After the eighth bit the count returns to zero, so consecutive bytes need no reselect.
- R9: `wr_valid` rises SYNC_STAGES+1 system clock edges after the eighth serial-clock rise is first seen at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_dat | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_dc | input | 1 | Data/command select, sampled on eighth edge |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| wr_valid | output | 1 | One-cycle strobe for a finished byte |
| wr_data | output | 8 | Finished byte |
| wr_is_data | output | 1 | 1 = display memory, 0 = command register |

## Verification
The strobe is due exactly SYNC_STAGES+1 system edges after the eighth serial-clock rise reaches the pin. The latency test drives that rise on a falling system edge, then samples `wr_valid` on the following falling edges: it must be 0 for SYNC_STAGES of them and 1 on the next. For every other test, a monitor runs on falling system edges and records each strobe's value, flag and width. Each serial phase is held for four system cycles, and the bench waits for the byte to drain before it compares the monitor's record against the value it computed from the bits it sent.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  localparam int unsigned BYTE_BITS = 8;

  // Next bit-count value, wrapping after the last bit of a byte.
  function automatic logic [$clog2(BYTE_BITS)-1:0] cnt_advance(
      input logic [$clog2(BYTE_BITS)-1:0] cur);
    if (cur == BYTE_BITS[$clog2(BYTE_BITS)-1:0] - 1'b1)
      cnt_advance = '0;
    else
      cnt_advance = cur + 1'b1;
  endfunction

  // Append the newest bit below the bits already received (MSB first).
  function automatic logic [BYTE_BITS-1:0] shift_in(
      input logic [BYTE_BITS-1:0] acc, input logic b);
    shift_in = {acc[BYTE_BITS-2:0], b};
  endfunction

  // Both chip selects in their active state.
  function automatic logic is_selected(input logic lo_n, input logic hi);
    is_selected = !lo_n && hi;
  endfunction
endpackage

// File: rtl/sdrx_sync.sv
module sdrx_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_async;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/sdrx_edge.sv
module sdrx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl && !prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sdrx_shift.sv
module sdrx_shift
  import sdrx_pkg::*;
#(
  parameter int unsigned BITS = BYTE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_evt,
  input  logic            sel,
  input  logic            dat,
  input  logic            dc,
  output logic            byte_done,
  output logic [BITS-1:0] byte_val,
  output logic            byte_dc,
  output logic [$clog2(BITS)-1:0] cnt
);
  localparam int unsigned CW = $clog2(BITS);

  logic [BITS-1:0] shreg_q;
  logic [CW-1:0]   cnt_q;
  logic            take_bit;

  assign take_bit  = bit_evt && sel;
  assign byte_done = take_bit && (cnt_q == CW'(BITS - 1));
  assign byte_val  = shift_in(shreg_q, dat);
  assign byte_dc   = dc;
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!sel) begin
      cnt_q   <= '0;
    end else if (take_bit) begin
      shreg_q <= shift_in(shreg_q, dat);
      cnt_q   <= cnt_advance(cnt_q);
    end
  end

  // R7
  desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> cnt_q == '0);
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> cnt_q == '0);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !bit_evt) |=> $stable(cnt_q) || !$past(sel));
endmodule

// File: rtl/serial_display_rx.sv
module serial_display_rx
  import sdrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_dc,
  input  logic       sel_lo_n,
  input  logic       sel_hi,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       wr_is_data
);
  localparam int unsigned NSIG = 5;
  localparam int unsigned CW   = $clog2(BYTE_BITS);

  logic [NSIG-1:0]      raw_in, syn;
  logic                 clk_rise, sel_now, byte_done, byte_dc;
  logic [BYTE_BITS-1:0] byte_val;
  logic [CW-1:0]        bit_cnt;

  assign raw_in = {ser_clk, ser_dat, ser_dc, sel_lo_n, sel_hi};

  sdrx_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(syn));

  sdrx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(syn[4]), .rise(clk_rise));

  assign sel_now = is_selected(syn[1], syn[0]);

  sdrx_shift #(.BITS(BYTE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_evt(clk_rise), .sel(sel_now),
    .dat(syn[3]), .dc(syn[2]), .byte_done(byte_done),
    .byte_val(byte_val), .byte_dc(byte_dc), .cnt(bit_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      wr_is_data <= 1'b0;
    end else begin
      wr_valid <= byte_done;
      if (byte_done) begin
        wr_data    <= byte_val;
        wr_is_data <= byte_dc;
      end
    end
  end

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> $stable(wr_data) && $stable(wr_is_data));
  // R6
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(clk_rise) && $past(sel_now));
  // R8
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(bit_cnt) == CW'(BYTE_BITS - 1));
endmodule

// File: tb/serial_display_rx_tb.sv
module serial_display_rx_tb;
  localparam int SYNC = 2;
  localparam int NV   = 6;
  // {dc, byte}
  localparam logic [8:0] VEC [NV] = '{
    9'h1_A5, 9'h0_3C, 9'h1_FF, 9'h0_00, 9'h1_81, 9'h0_5E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_dc = 1'b0;
  logic sel_lo_n = 1'b1, sel_hi = 1'b0;
  logic wr_valid, wr_is_data;
  logic [7:0] wr_data;

  int checks = 0, failures = 0;
  int pulses = 0, wide = 0;
  logic [7:0] got_b = '0;
  logic got_dc = 1'b0, prev_v = 1'b0;

  always #2.5 clk = ~clk;

  serial_display_rx #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_dc(ser_dc), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_is_data(wr_is_data));

  always @(negedge clk) begin
    if (wr_valid) begin
      pulses++;
      got_b  = wr_data;
      got_dc = wr_is_data;
      if (prev_v) wide++;
    end
    prev_v = wr_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send nb bits of v MSB first; dc is inverted except on bit index 7 of the byte.
  task automatic send_bits(input logic [7:0] v, input int nb, input logic dc);
    for (int i = 0; i < nb; i++) begin
      ser_clk = 1'b0;
      ser_dat = v[7-i];
      ser_dc  = (i == 7) ? dc : ~dc;
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
    end
  endtask

  task automatic drain();
    ser_clk = 1'b0;
    wait_n(SYNC + 6);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_n(4);
    // R1
    chk(wr_valid == 1'b0 && wr_data == 8'h00 && wr_is_data == 1'b0, "R1",
        {wr_valid, wr_data, wr_is_data}, 0);
    rst_n = 1'b1;
    wait_n(3);
    chk(wr_valid == 1'b0 && wr_data == 8'h00, "R1", {wr_valid, wr_data}, 0);
    sel_lo_n = 1'b0; sel_hi = 1'b1;
    wait_n(4);

    // R2 R3 R8: back-to-back vector stream, no reselect
    for (int k = 0; k < NV; k++) begin
      pulses = 0;
      send_bits(VEC[k][7:0], 8, VEC[k][8]);
      drain();
      chk(got_b == VEC[k][7:0], "R2", got_b, VEC[k][7:0]);
      chk(got_dc == VEC[k][8], "R3", got_dc, VEC[k][8]);
      chk(pulses == 1, "R8", pulses, 1);
    end
    chk(wide == 0, "R4", wide, 0);

    // R5: outputs hold with no traffic
    wait_n(20);
    chk(wr_data == VEC[NV-1][7:0] && wr_is_data == VEC[NV-1][8], "R5",
        {wr_is_data, wr_data}, VEC[NV-1]);

    // R6: high select inactive -> edges ignored, count untouched
    pulses = 0;
    sel_hi = 1'b0; wait_n(4);
    send_bits(8'hC3, 8, 1'b1); drain();
    chk(pulses == 0, "R6", pulses, 0);
    sel_hi = 1'b1; wait_n(4);
    send_bits(8'h6B, 8, 1'b0); drain();
    chk(pulses == 1 && got_b == 8'h6B, "R6", got_b, 8'h6B);

    // R6: low select inactive
    pulses = 0;
    sel_lo_n = 1'b1; wait_n(4);
    send_bits(8'h12, 8, 1'b1); drain();
    chk(pulses == 0, "R6", pulses, 0);
    sel_lo_n = 1'b0; wait_n(4);

    // R7: partial byte discarded by deselect
    pulses = 0;
    send_bits(8'hE0, 3, 1'b1);
    ser_clk = 1'b0;
    sel_lo_n = 1'b1; wait_n(SYNC + 4);
    sel_lo_n = 1'b0; wait_n(SYNC + 4);
    send_bits(8'h96, 8, 1'b1); drain();
    chk(pulses == 1, "R7", pulses, 1);
    chk(got_b == 8'h96 && got_dc == 1'b1, "R7", got_b, 8'h96);

    // R9 latency and R4 width
    pulses = 0;
    send_bits(8'h4D, 7, 1'b0);
    ser_clk = 1'b0; ser_dat = 1'b1; ser_dc = 1'b0;
    wait_n(4);
    ser_clk = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk);
      chk(wr_valid == 1'b0, "R9", wr_valid, 0);
    end
    @(negedge clk);
    chk(wr_valid == 1'b1, "R9", wr_valid, 1);
    chk(wr_data == 8'h4D && wr_is_data == 1'b0, "R9", wr_data, 8'h4D);
    @(negedge clk);
    chk(wr_valid == 1'b0, "R4", wr_valid, 0);
    drain();
    chk(pulses == 1 && wide == 0, "R4", pulses, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule